// File: doc/BRIEF.md
# Converter Status Flag Controller

This block holds the digital bookkeeping that sits beside a serial-access measurement converter. A byte written to the communications register chooses which of eight register types the next serial access reaches. For every access the block reports that target as a small code. The same code that names the communications register on a write names the status register on a read. A write whose reserved bit is set is refused and flagged.

The block also keeps an 8-bit read-only status word. It has four live flags: result-ready, filter-settled, standby and missing-reference. Below them sits a fixed identification nibble. The analog front end, the filter arithmetic and the serial shifter are outside the block. It sees them only as strobes and levels: result available, data register read, fast-step response active, reference low, standby pin, mode code and calibration done. The block also owns the 24-bit data register and the offset and gain calibration registers. A missing reference replaces the result with all ones and blocks calibration updates.

Top module: `cnv_status_ctl`

## Requirements
- R1: After a communications write with bit 3 = 0, the select field is bits 2:0 of that byte. `acc_tgt` then reads as follows: 0 comm, 1 data, 2 mode, 3 filter, 4 DAC, 5 offset, 6 gain, 7 test. The one exception is select 0 while `acc_is_rd` = 1, which gives 8 (status).
- R2: A communications write with bit 3 = 1 leaves the select field unchanged. It raises `comm_err` for exactly the following cycle.
- R3: `status_word` is {ready, settled, standby, no-ref, ID}, with ready in bit 7 (shifted first), settled in bit 6, standby in bit 5, no-ref in bit 4 and ID in bits 3:0. ID is the parameter `ID_NIBBLE`, default 4'b1100.
- R4: During and after reset, ready = 1, settled = 1 and no-ref = 0. The data, offset and gain registers are 0, the select field is 0 and `comm_err` is 0.
- R5: A `res_strobe` clears ready on the next cycle. On that same next cycle the data register holds `result_in`.
- R6: A result that arrives while `fstep_active` = 1 leaves settled at 1 and arms a pending state. The first later result that arrives with `fstep_active` = 0 clears settled and ready together and ends the pending state.
- R7: When no fast-step response is pending, a data read clears settled on the next cycle. Further reads do not set it again, and results do not change it.
- R8: A `data_rd` sets ready on the next cycle. A `res_strobe` in the same cycle overrides this and leaves ready at 0.
- R9: A change of `mode_code` between cycles sets both ready and settled on the next cycle and ends any pending fast-step state. A `res_strobe` in the same cycle overrides this.
- R10: The standby bit equals the registered value of (`stby_pin` OR `mode_code` == 3'b011), one cycle behind its inputs.
- R11: The no-ref bit is `ref_low` registered by one cycle. A result taken while no-ref = 1 loads the data register with all ones.
- R12: A `cal_done` while no-ref = 0 loads `cal_off_in` and `cal_gain_in` into the offset and gain registers on the next cycle. While no-ref = 1, both registers stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| comm_wr | input | 1 | Communications register write strobe |
| comm_din | input | 8 | Byte written to the communications register |
| acc_is_rd | input | 1 | Next serial access is a read |
| acc_tgt | output | 4 | Target code of the next access |
| comm_err | output | 1 | One-cycle flag for an illegal communications write |
| res_strobe | input | 1 | New conversion result available |
| result_in | input | DATA_W | Conversion result |
| data_rd | input | 1 | Data register read completed |
| fstep_active | input | 1 | Fast-step filter responding to a step |
| ref_low | input | 1 | Reference voltage below threshold |
| stby_pin | input | 1 | Standby request pin (active high) |
| mode_code | input | 3 | Operating mode field |
| cal_done | input | 1 | Calibration complete strobe |
| cal_off_in | input | CAL_W | New offset coefficient |
| cal_gain_in | input | CAL_W | New gain coefficient |
| status_word | output | 8 | Status register contents |
| data_reg | output | DATA_W | Data register |
| offset_reg | output | CAL_W | Offset calibration register |
| gain_reg | output | CAL_W | Gain calibration register |

## Verification
Three events act on ready in the same cycle and compete for it: a new result, a data read and a mode change. A new result and a data read can also compete for settled. The bench drives a pseudo-random pattern of result, read and fast-step levels, so these strobes meet and miss each other in every combination. A bench-side model, built only from the priority rules, judges each cycle's ready and settled bits. Directed steps add two more cases. In one, a mode change and a result arrive together. In the other, a result arrives while the reference is missing.

// File: rtl/cnv_pkg.sv
package cnv_pkg;

    typedef enum logic [3:0] {
        TGT_COMM = 4'd0,
        TGT_DATA = 4'd1,
        TGT_MODE = 4'd2,
        TGT_FILT = 4'd3,
        TGT_DAC  = 4'd4,
        TGT_OFFS = 4'd5,
        TGT_GAIN = 4'd6,
        TGT_TEST = 4'd7,
        TGT_STAT = 4'd8
    } tgt_e;

    typedef struct packed {
        logic       rdy;
        logic       stdy;
        logic       stby;
        logic       noref;
        logic [3:0] id;
    } stat_t;

    localparam int          SEL_W     = 3;
    localparam int          RSV_BIT   = 3;
    localparam logic [2:0]  MODE_STBY = 3'b011;

    function automatic tgt_e sel_to_tgt(input logic [SEL_W-1:0] sel, input logic is_rd);
        tgt_e t;
        if (sel == '0 && is_rd) t = TGT_STAT;
        else                    t = tgt_e'({1'b0, sel});
        return t;
    endfunction

endpackage

// File: rtl/cnv_sel_decode.sv
module cnv_sel_decode
    import cnv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       comm_wr,
    input  logic [7:0] comm_din,
    input  logic       acc_is_rd,
    output tgt_e       tgt,
    output logic       err
);
    logic [SEL_W-1:0] sel_q;
    logic             illegal;

    assign illegal = comm_din[RSV_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            err   <= 1'b0;
        end else begin
            err <= comm_wr && illegal;
            if (comm_wr && !illegal) sel_q <= comm_din[SEL_W-1:0];
        end
    end

    assign tgt = sel_to_tgt(sel_q, acc_is_rd);
endmodule

// File: rtl/cnv_flag_ctl.sv
module cnv_flag_ctl (
    input  logic       clk,
    input  logic       rst,
    input  logic       res_strobe,
    input  logic       data_rd,
    input  logic       fstep_active,
    input  logic [2:0] mode_code,
    output logic       rdy,
    output logic       stdy
);
    logic [2:0] mode_q;
    logic       pend_q;
    logic       mode_chg;

    assign mode_chg = (mode_code != mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy    <= 1'b1;
            stdy   <= 1'b1;
            pend_q <= 1'b0;
            mode_q <= mode_code;
        end else begin
            mode_q <= mode_code;
            if (res_strobe) begin
                rdy <= 1'b0;
                if (fstep_active) begin
                    stdy   <= 1'b1;
                    pend_q <= 1'b1;
                end else if (pend_q) begin
                    stdy   <= 1'b0;
                    pend_q <= 1'b0;
                end
            end else if (mode_chg) begin
                rdy    <= 1'b1;
                stdy   <= 1'b1;
                pend_q <= 1'b0;
            end else if (data_rd) begin
                rdy <= 1'b1;
                if (!pend_q) stdy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cnv_data_path.sv
module cnv_data_path
    import cnv_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int CAL_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              res_strobe,
    input  logic [DATA_W-1:0] result_in,
    input  logic              cal_done,
    input  logic [CAL_W-1:0]  cal_off_in,
    input  logic [CAL_W-1:0]  cal_gain_in,
    input  logic              ref_low,
    input  logic              stby_pin,
    input  logic [2:0]        mode_code,
    output logic              noref,
    output logic              stby,
    output logic [DATA_W-1:0] data_q,
    output logic [CAL_W-1:0]  off_q,
    output logic [CAL_W-1:0]  gain_q
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    logic stby_req;
    assign stby_req = stby_pin || (mode_code == MODE_STBY);

    always_ff @(posedge clk) begin
        if (rst) begin
            noref  <= 1'b0;
            stby   <= stby_req;
            data_q <= '0;
            off_q  <= '0;
            gain_q <= '0;
        end else begin
            noref <= ref_low;
            stby  <= stby_req;
            if (res_strobe) data_q <= noref ? ALL_ONES : result_in;
            if (cal_done && !noref) begin
                off_q  <= cal_off_in;
                gain_q <= cal_gain_in;
            end
        end
    end
endmodule

// File: rtl/cnv_status_ctl.sv
module cnv_status_ctl
    import cnv_pkg::*;
#(
    parameter int         DATA_W    = 24,
    parameter int         CAL_W     = 24,
    parameter logic [3:0] ID_NIBBLE = 4'b1100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              comm_wr,
    input  logic [7:0]        comm_din,
    input  logic              acc_is_rd,
    output logic [3:0]        acc_tgt,
    output logic              comm_err,
    input  logic              res_strobe,
    input  logic [DATA_W-1:0] result_in,
    input  logic              data_rd,
    input  logic              fstep_active,
    input  logic              ref_low,
    input  logic              stby_pin,
    input  logic [2:0]        mode_code,
    input  logic              cal_done,
    input  logic [CAL_W-1:0]  cal_off_in,
    input  logic [CAL_W-1:0]  cal_gain_in,
    output logic [7:0]        status_word,
    output logic [DATA_W-1:0] data_reg,
    output logic [CAL_W-1:0]  offset_reg,
    output logic [CAL_W-1:0]  gain_reg
);
    tgt_e  tgt;
    stat_t st;
    logic  rdy, stdy, stby, noref;

    cnv_sel_decode u_sel (
        .clk       (clk),
        .rst       (rst),
        .comm_wr   (comm_wr),
        .comm_din  (comm_din),
        .acc_is_rd (acc_is_rd),
        .tgt       (tgt),
        .err       (comm_err)
    );

    cnv_flag_ctl u_flag (
        .clk          (clk),
        .rst          (rst),
        .res_strobe   (res_strobe),
        .data_rd      (data_rd),
        .fstep_active (fstep_active),
        .mode_code    (mode_code),
        .rdy          (rdy),
        .stdy         (stdy)
    );

    cnv_data_path #(.DATA_W(DATA_W), .CAL_W(CAL_W)) u_dp (
        .clk         (clk),
        .rst         (rst),
        .res_strobe  (res_strobe),
        .result_in   (result_in),
        .cal_done    (cal_done),
        .cal_off_in  (cal_off_in),
        .cal_gain_in (cal_gain_in),
        .ref_low     (ref_low),
        .stby_pin    (stby_pin),
        .mode_code   (mode_code),
        .noref       (noref),
        .stby        (stby),
        .data_q      (data_reg),
        .off_q       (offset_reg),
        .gain_q      (gain_reg)
    );

    always_comb begin
        st.rdy   = rdy;
        st.stdy  = stdy;
        st.stby  = stby;
        st.noref = noref;
        st.id    = ID_NIBBLE;
    end

    assign status_word = st;
    assign acc_tgt     = tgt;
endmodule

// File: rtl/cnv_status_ctl_chk.sv
module cnv_status_ctl_chk #(
    parameter int DATA_W = 24,
    parameter int CAL_W  = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              comm_wr,
    input logic [7:0]        comm_din,
    input logic              comm_err,
    input logic              res_strobe,
    input logic              data_rd,
    input logic              fstep_active,
    input logic              stby_pin,
    input logic [2:0]        mode_code,
    input logic              cal_done,
    input logic [7:0]        status_word,
    input logic [DATA_W-1:0] data_reg,
    input logic [CAL_W-1:0]  offset_reg,
    input logic [CAL_W-1:0]  gain_reg
);
    AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (rst)
        comm_wr && comm_din[3] |=> comm_err); // R2
    AST_ERR_ONLY_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        comm_err |-> $past(comm_wr && comm_din[3])); // R2
    AST_RES_CLR_RDY: assert property (@(posedge clk) disable iff (rst)
        res_strobe |=> !status_word[7]); // R5
    AST_FSTEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        res_strobe && fstep_active |=> status_word[6]); // R6
    AST_RD_SET_RDY: assert property (@(posedge clk) disable iff (rst)
        data_rd && !res_strobe |=> status_word[7]); // R8
    AST_STBY_TRACK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> status_word[5] == $past(stby_pin || mode_code == 3'b011)); // R10
    AST_NOREF_DATA: assert property (@(posedge clk) disable iff (rst)
        res_strobe && status_word[4] |=> &data_reg); // R11
    AST_NOREF_CAL: assert property (@(posedge clk) disable iff (rst)
        cal_done && status_word[4] |=> $stable(offset_reg) && $stable(gain_reg)); // R12
endmodule

bind cnv_status_ctl cnv_status_ctl_chk #(.DATA_W(DATA_W), .CAL_W(CAL_W)) u_chk (.*);

// File: tb/cnv_status_ctl_bench.sv
module cnv_status_ctl_bench;
    localparam int DW = 24;
    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst;
    logic          comm_wr, acc_is_rd, res_strobe, data_rd, fstep_active;
    logic          ref_low, stby_pin, cal_done;
    logic [7:0]    comm_din;
    logic [2:0]    mode_code;
    logic [DW-1:0] result_in;
    logic [CW-1:0] cal_off_in, cal_gain_in;
    logic [3:0]    acc_tgt;
    logic          comm_err;
    logic [7:0]    status_word;
    logic [DW-1:0] data_reg;
    logic [CW-1:0] offset_reg, gain_reg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cnv_status_ctl u_cnv_status_ctl (
        .clk(clk), .rst(rst), .comm_wr(comm_wr), .comm_din(comm_din),
        .acc_is_rd(acc_is_rd), .acc_tgt(acc_tgt), .comm_err(comm_err),
        .res_strobe(res_strobe), .result_in(result_in), .data_rd(data_rd),
        .fstep_active(fstep_active), .ref_low(ref_low), .stby_pin(stby_pin),
        .mode_code(mode_code), .cal_done(cal_done), .cal_off_in(cal_off_in),
        .cal_gain_in(cal_gain_in), .status_word(status_word),
        .data_reg(data_reg), .offset_reg(offset_reg), .gain_reg(gain_reg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at negedge, one posedge, sample at the following negedge
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        comm_wr = 0; res_strobe = 0; data_rd = 0; cal_done = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        logic       m_rdy, m_stdy, m_pend;
        rst = 1; idle(); comm_din = 0; acc_is_rd = 0; fstep_active = 0;
        ref_low = 0; stby_pin = 0; mode_code = 0; result_in = 0;
        cal_off_in = 0; cal_gain_in = 0;
        repeat (3) @(negedge clk);
        // R4 / R3 reset state
        chk("R4 status", {24'd0, status_word}, {24'd0, 8'b1100_1100});
        chk("R4 data", data_reg, 0);
        chk("R4 offset", offset_reg, 0);
        chk("R4 gain", gain_reg, 0);
        chk("R4 err", comm_err, 0);
        chk("R4 tgt", acc_tgt, 0);
        rst = 0;
        tick();
        chk("R3 id nibble", status_word[3:0], 4'b1100);

        // R1 / R2 sweep of every byte low nibble and both directions
        for (int c = 0; c < 16; c++) begin
            int k;
            k = (c + 3) % 8;
            comm_wr = 1; comm_din = 8'(k); tick();
            comm_din = 8'(c); tick();
            comm_wr = 0; comm_din = 0;
            chk("R2 err pulse", comm_err, (c >= 8) ? 1 : 0);
            for (int rd = 0; rd < 2; rd++) begin
                int code, exp_t;
                acc_is_rd = rd[0];
                #1;
                code  = (c >= 8) ? k : c;
                exp_t = (code == 0 && rd == 1) ? 8 : code;
                chk((c >= 8) ? "R2 select kept" : "R1 target", acc_tgt, exp_t);
            end
            acc_is_rd = 0;
            tick();
            chk("R2 err one cycle", comm_err, 0);
        end

        // R5..R8 sweep against a priority model
        rst = 1; tick(); rst = 0;
        m_rdy = 1; m_stdy = 1; m_pend = 0;
        lfsr = 8'h5a;
        for (int s = 0; s < 160; s++) begin
            res_strobe   = lfsr[0];
            data_rd      = lfsr[1] | lfsr[2];
            fstep_active = lfsr[3] & (s < 80) & lfsr[4];
            result_in    = {lfsr, ~lfsr, lfsr};
            if (res_strobe) begin
                m_rdy = 0;
                if (fstep_active) begin m_stdy = 1; m_pend = 1; end
                else if (m_pend) begin m_stdy = 0; m_pend = 0; end
            end else if (data_rd) begin
                m_rdy = 1;
                if (!m_pend) m_stdy = 0;
            end
            tick();
            chk("R8 ready", status_word[7], m_rdy);
            chk("R6 R7 settled", status_word[6], m_stdy);
            if (res_strobe) chk("R5 data load", data_reg, {lfsr, ~lfsr, lfsr});
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        idle(); fstep_active = 0;

        // R7 directed: read clears settled, stays low
        data_rd = 1; tick(); data_rd = 0;
        chk("R7 settled cleared", status_word[6], 0);
        res_strobe = 1; tick(); res_strobe = 0;
        chk("R7 result keeps settled", status_word[6], 0);
        data_rd = 1; tick(); data_rd = 0;
        chk("R7 read keeps settled", status_word[6], 0);

        // R9 mode change sets both
        mode_code = 3'd1; tick();
        chk("R9 ready", status_word[7], 1);
        chk("R9 settled", status_word[6], 1);
        data_rd = 1; tick(); data_rd = 0;
        mode_code = 3'd2; res_strobe = 1; tick(); res_strobe = 0;
        chk("R9 result wins", status_word[7], 0);

        // R10 standby sweep
        for (int p = 0; p < 2; p++) begin
            for (int m = 0; m < 8; m++) begin
                stby_pin = p[0]; mode_code = 3'(m); tick();
                chk("R10 standby", status_word[5], (p == 1 || m == 3) ? 1 : 0);
            end
        end
        stby_pin = 0; mode_code = 0; tick();

        // R12 calibration with reference present
        cal_off_in = 24'h123456; cal_gain_in = 24'h654321;
        cal_done = 1; tick(); cal_done = 0;
        chk("R12 offset load", offset_reg, 24'h123456);
        chk("R12 gain load", gain_reg, 24'h654321);

        // R11 missing reference
        ref_low = 1; tick();
        chk("R11 noref flag", status_word[4], 1);
        result_in = 24'h000abc; res_strobe = 1; tick(); res_strobe = 0;
        chk("R11 data all ones", data_reg, 24'hffffff);
        cal_off_in = 24'h111111; cal_gain_in = 24'h222222;
        cal_done = 1; tick(); cal_done = 0;
        chk("R12 offset held", offset_reg, 24'h123456);
        chk("R12 gain held", gain_reg, 24'h654321);
        ref_low = 0; tick();
        chk("R11 noref clear", status_word[4], 0);
        result_in = 24'h000abc; res_strobe = 1; tick(); res_strobe = 0;
        chk("R11 normal data", data_reg, 24'h000abc);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule